// File: doc/BRIEF.md
# One-Time-Programmable Memory Program-and-Verify Sequencer

This block drives a one-time-programmable word array through a fast programming algorithm. After a start request it asks for the high programming supply and then runs a blind pass. In that pass every address, in ascending order, receives a single program pulse and is not read. A second pass reads each word back and compares it with the expected value. On a mismatch the block fires further pulses, with a read after each one, until the word holds its value or a retry budget runs out. Once every word has verified, the block asks for the nominal supply and reads the whole array once more as a final compare.

The expected word for the address currently presented comes from an outside data source. The array returns its stored word on the read-data input in the same cycle. Pulse width and settling gaps are counted in clock cycles. A check at elaboration refuses a pulse width that falls outside the legal 45 to 55 microsecond window for the given clock rate. The run ends in a held done state that reports pass or fail. On a fail it also reports the first failing address and the phase in which that address failed.

Top module: `otp_prog_seq`

## Requirements
- R1: A start request in the idle or done state raises the supply request to programming level (code 1) at address 0 and holds it for SETUP_CYC cycles before the first pulse. A start request while a run is in progress has no effect on any output.
- R2: In the blind pass each address, in ascending order, gets exactly one program pulse of PULSE_CYC cycles followed by SETUP_CYC idle cycles. The verify strobe stays low throughout this pass.
- R3: In the verify pass the verify strobe is high for one cycle per attempt. If the read-back word equals the expected word, the next address is verified in the very next cycle.
- R4: If a verify attempt mismatches and the retry budget is not used up, the block applies one further pulse of PULSE_CYC cycles and then SETUP_CYC idle cycles, and verifies the same address again. The retry count restarts at zero for every address.
- R5: If a word still mismatches after RETRY_MAX retry pulses, the next cycle is done with fail asserted, fail phase code 1 and the failing address latched. No further address is touched.
- R6: After the last word verifies, the supply request changes to nominal read level (code 2) for SETUP_CYC cycles at address 0. Then every address is read once, one per cycle in ascending order, with the verify strobe high.
- R7: A read-back mismatch in the final pass sets fail phase code 2 and latches the first mismatching address. The remaining words are still read before done.
- R8: Done, pass and fail hold their values until the next start. Pass is asserted when done is reached with no recorded failure. Pass and fail are never both high.
- R9: After reset, the supply request is off (code 0) and the pulse, verify, done, pass and fail outputs are all low.
- R10: The program pulse and the verify strobe are never high together. While a pulse is active, the write data equals the expected word for the presented address and the supply request is at programming level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a programming run (acted on only when idle or done) |
| exp_data_i | input | DW | Expected word for the address on addr_o |
| addr_o | output | AW | Word address presented to the array |
| wdata_o | output | DW | Word to program |
| pgm_pulse_o | output | 1 | Program pulse strobe |
| verify_o | output | 1 | Read strobe; rdata_i is compared in this cycle |
| rdata_i | input | DW | Word read back from the array |
| supply_o | output | 2 | Supply request: 0 off, 1 programming, 2 nominal read |
| done_o | output | 1 | Run finished |
| pass_o | output | 1 | Run finished with every word correct |
| fail_o | output | 1 | Run finished with a failure |
| fail_addr_o | output | AW | First failing address |
| fail_phase_o | output | 2 | 0 none, 1 retry budget exhausted, 2 final read-back mismatch |

## Verification
The bench covers two cases where one cycle carries two decisions. In the first, the last address of the array exhausts its retry budget, so the end-of-array step and the retry-limit decision compete in the same verify cycle. In the second, only the last word is corrupted during the final read-back, so recording the mismatch coincides with the move to done. The array model makes the last word need one pulse more than the budget allows in the first case, and flips that word only at nominal supply in the second. The bench then checks, cycle by cycle, that done follows at once with the expected phase code and address 15. A third run sets one word to need exactly the full budget, to show that this word still passes.

// File: rtl/otp_prog_pkg.sv
package otp_prog_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_RAMP_HI,
    S_BLIND_PULSE,
    S_BLIND_GAP,
    S_VERIFY,
    S_RETRY_PULSE,
    S_RETRY_GAP,
    S_RAMP_LO,
    S_READBACK,
    S_DONE
  } seq_state_e;

  typedef enum logic [1:0] {
    SUP_OFF  = 2'd0,
    SUP_PROG = 2'd1,
    SUP_READ = 2'd2
  } supply_e;

  typedef enum logic [1:0] {
    PH_NONE     = 2'd0,
    PH_VERIFY   = 2'd1,
    PH_READBACK = 2'd2
  } fail_phase_e;

endpackage

// File: rtl/otp_cycle_timer.sv
// Free-running cycle counter with synchronous clear; flags the last cycle
// of a window whose length is given on limit_i.
module otp_cycle_timer #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic [CW-1:0] limit_i,
  output logic          last_o
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = clr_i ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign last_o = (cnt_q == limit_i - CW'(1));
endmodule

// File: rtl/otp_word_cursor.sv
// Address walker and per-address retry counter.
module otp_word_cursor #(
  parameter int AW        = 4,
  parameter int RETRY_MAX = 10,
  localparam int RW       = $clog2(RETRY_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          addr_clr_i,
  input  logic          addr_inc_i,
  input  logic          rty_clr_i,
  input  logic          rty_inc_i,
  output logic [AW-1:0] addr_o,
  output logic          addr_last_o,
  output logic          rty_max_o
);
  logic [AW-1:0] addr_q, addr_d;
  logic          addr_en;
  logic [RW-1:0] rty_q, rty_d;
  logic          rty_en;

  always_comb begin
    addr_en = addr_clr_i | addr_inc_i;
    addr_d  = addr_clr_i ? '0 : addr_q + AW'(1);
    rty_en  = rty_clr_i | rty_inc_i;
    rty_d   = rty_clr_i ? '0 : rty_q + RW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  // R4: retry count restarts for each address
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rty_q <= '0;
    else if (rty_en) rty_q <= rty_d;
  end

  assign addr_o      = addr_q;
  assign addr_last_o = &addr_q;
  assign rty_max_o   = (rty_q == RW'(RETRY_MAX));
endmodule

// File: rtl/otp_fail_log.sv
// Keeps the first failure of a run (address and phase).
module otp_fail_log
  import otp_prog_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          rec_i,
  input  logic [AW-1:0] addr_i,
  input  fail_phase_e   phase_i,
  output logic          flag_o,
  output logic [AW-1:0] addr_o,
  output fail_phase_e   phase_o
);
  logic take;

  assign take = rec_i & ~flag_o & ~clr_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_o <= 1'b0;
    else if (clr_i) flag_o <= 1'b0;
    else if (take)  flag_o <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_o  <= '0;
      phase_o <= PH_NONE;
    end else if (clr_i) begin
      addr_o  <= '0;
      phase_o <= PH_NONE;
    end else if (take) begin
      addr_o  <= addr_i;
      phase_o <= phase_i;
    end
  end
endmodule

// File: rtl/otp_prog_seq.sv
module otp_prog_seq
  import otp_prog_pkg::*;
#(
  parameter int AW         = 4,
  parameter int DW         = 16,
  parameter int CYC_PER_US = 1,
  parameter int PULSE_CYC  = 50,
  parameter int SETUP_CYC  = 2,
  parameter int RETRY_MAX  = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [DW-1:0] exp_data_i,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic          pgm_pulse_o,
  output logic          verify_o,
  input  logic [DW-1:0] rdata_i,
  output logic [1:0]    supply_o,
  output logic          done_o,
  output logic          pass_o,
  output logic          fail_o,
  output logic [AW-1:0] fail_addr_o,
  output logic [1:0]    fail_phase_o
);
  localparam int PULSE_MIN_CYC = 45 * CYC_PER_US;
  localparam int PULSE_MAX_CYC = 55 * CYC_PER_US;
  localparam int TW            = $clog2(PULSE_CYC + SETUP_CYC + 1);

  generate
    if (PULSE_CYC < PULSE_MIN_CYC || PULSE_CYC > PULSE_MAX_CYC) begin : g_bad_pulse
      $error("program pulse length outside the 45..55 us window");
    end
    if (SETUP_CYC < 1 || RETRY_MAX < 1) begin : g_bad_gap
      $error("settling gap and retry limit must be at least 1");
    end
  endgenerate

  seq_state_e  state_q, state_d;
  logic        tmr_clr, tmr_last;
  logic [TW-1:0] tmr_limit;
  logic        addr_clr, addr_inc, rty_clr, rty_inc;
  logic        addr_last, rty_max;
  logic        log_clr, log_rec, log_flag;
  fail_phase_e log_phase, log_phase_q;
  logic        word_ok;
  supply_e     supply;

  assign word_ok = (rdata_i == exp_data_i);

  // next-state process
  always_comb begin
    state_d   = state_q;
    addr_clr  = 1'b0;
    addr_inc  = 1'b0;
    rty_clr   = 1'b0;
    rty_inc   = 1'b0;
    log_clr   = 1'b0;
    log_rec   = 1'b0;
    log_phase = PH_NONE;
    case (state_q)
      S_IDLE, S_DONE: begin
        // R1: start only honoured when not running
        if (start_i) begin
          state_d  = S_RAMP_HI;
          addr_clr = 1'b1;
          rty_clr  = 1'b1;
          log_clr  = 1'b1;
        end
      end
      S_RAMP_HI:     if (tmr_last) state_d = S_BLIND_PULSE;
      S_BLIND_PULSE: if (tmr_last) state_d = S_BLIND_GAP;
      S_BLIND_GAP: begin
        // R2: one pulse per address, then on to the verify pass
        if (tmr_last) begin
          if (addr_last) begin
            state_d  = S_VERIFY;
            addr_clr = 1'b1;
            rty_clr  = 1'b1;
          end else begin
            state_d  = S_BLIND_PULSE;
            addr_inc = 1'b1;
          end
        end
      end
      S_VERIFY: begin
        if (word_ok) begin
          // R3: advance immediately on a match
          rty_clr = 1'b1;
          if (addr_last) begin
            state_d  = S_RAMP_LO;
            addr_clr = 1'b1;
          end else begin
            addr_inc = 1'b1;
          end
        end else if (rty_max) begin
          // R5: budget spent
          state_d   = S_DONE;
          log_rec   = 1'b1;
          log_phase = PH_VERIFY;
        end else begin
          // R4: one more pulse
          rty_inc = 1'b1;
          state_d = S_RETRY_PULSE;
        end
      end
      S_RETRY_PULSE: if (tmr_last) state_d = S_RETRY_GAP;
      S_RETRY_GAP:   if (tmr_last) state_d = S_VERIFY;
      S_RAMP_LO:     if (tmr_last) state_d = S_READBACK;
      S_READBACK: begin
        // R7: record first mismatch, keep reading
        if (!word_ok) begin
          log_rec   = 1'b1;
          log_phase = PH_READBACK;
        end
        if (addr_last) state_d = S_DONE;
        else           addr_inc = 1'b1;
      end
      default: state_d = S_IDLE;
    endcase
  end

  // state register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end

  assign tmr_clr   = (state_d != state_q);
  assign tmr_limit = (state_q == S_BLIND_PULSE || state_q == S_RETRY_PULSE)
                     ? TW'(PULSE_CYC) : TW'(SETUP_CYC);

  otp_cycle_timer #(.CW(TW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (tmr_clr),
    .limit_i (tmr_limit),
    .last_o  (tmr_last)
  );

  otp_word_cursor #(.AW(AW), .RETRY_MAX(RETRY_MAX)) u_cursor (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr_clr_i  (addr_clr),
    .addr_inc_i  (addr_inc),
    .rty_clr_i   (rty_clr),
    .rty_inc_i   (rty_inc),
    .addr_o      (addr_o),
    .addr_last_o (addr_last),
    .rty_max_o   (rty_max)
  );

  otp_fail_log #(.AW(AW)) u_log (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (log_clr),
    .rec_i   (log_rec),
    .addr_i  (addr_o),
    .phase_i (log_phase),
    .flag_o  (log_flag),
    .addr_o  (fail_addr_o),
    .phase_o (log_phase_q)
  );

  // R6 / R9 / R10: Moore output decode
  always_comb begin
    case (state_q)
      S_RAMP_HI, S_BLIND_PULSE, S_BLIND_GAP,
      S_VERIFY, S_RETRY_PULSE, S_RETRY_GAP: supply = SUP_PROG;
      S_RAMP_LO, S_READBACK:                supply = SUP_READ;
      default:                              supply = SUP_OFF;
    endcase
  end

  assign supply_o     = supply;
  assign pgm_pulse_o  = (state_q == S_BLIND_PULSE) || (state_q == S_RETRY_PULSE);
  assign verify_o     = (state_q == S_VERIFY) || (state_q == S_READBACK);
  assign wdata_o      = exp_data_i;
  assign done_o       = (state_q == S_DONE);
  assign pass_o       = done_o & ~log_flag;
  assign fail_o       = done_o & log_flag;
  assign fail_phase_o = log_phase_q;
endmodule

// File: rtl/otp_prog_seq_chk.sv
module otp_prog_seq_chk #(
  parameter int AW        = 4,
  parameter int PULSE_CYC = 50
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          pgm_i,
  input logic          verify_i,
  input logic [1:0]    supply_i,
  input logic [AW-1:0] addr_i,
  input logic          done_i,
  input logic          pass_i,
  input logic          fail_i,
  input logic [1:0]    phase_i
);
  int run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     run_len <= 0;
    else if (pgm_i) run_len <= run_len + 1;
    else            run_len <= 0;
  end

  a_r10_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(pgm_i && verify_i));

  a_r10_pulse_at_prog_supply: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_i |-> supply_i == 2'd1);

  a_r2_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pgm_i) |-> run_len == PULSE_CYC);

  a_r2_addr_steady_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (pgm_i && !$fell(pgm_i)) |=> (!pgm_i || $stable(addr_i)));

  a_r6_verify_powered: assert property (@(posedge clk) disable iff (!rst_n)
    verify_i |-> supply_i != 2'd0);

  a_r8_done_held: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && !start_i) |=> (done_i && $stable(pass_i) && $stable(fail_i)));

  a_r8_pass_fail_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass_i && fail_i));

  a_r5_fail_has_phase: assert property (@(posedge clk) disable iff (!rst_n)
    fail_i |-> phase_i != 2'd0);
endmodule

bind otp_prog_seq otp_prog_seq_chk #(.AW(AW), .PULSE_CYC(PULSE_CYC)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start_i  (start_i),
  .pgm_i    (pgm_pulse_o),
  .verify_i (verify_o),
  .supply_i (supply_o),
  .addr_i   (addr_o),
  .done_i   (done_o),
  .pass_i   (pass_o),
  .fail_i   (fail_o),
  .phase_i  (fail_phase_o)
);

// File: tb/otp_prog_seq_test.sv
`timescale 1ns/1ps
module otp_prog_seq_test;
  localparam int AW = 4, DW = 16, NW = 16;
  localparam int PCYC = 50, SCYC = 2, RMAX = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [DW-1:0] exp_data, wdata, rdata;
  logic [AW-1:0] addr, fail_addr;
  logic pgm, ver, done, pass, fail;
  logic [1:0] sup, fail_phase;

  always #2.5 clk = ~clk;

  otp_prog_seq #(.AW(AW), .DW(DW), .CYC_PER_US(1), .PULSE_CYC(PCYC),
                 .SETUP_CYC(SCYC), .RETRY_MAX(RMAX)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .exp_data_i(exp_data),
    .addr_o(addr), .wdata_o(wdata), .pgm_pulse_o(pgm), .verify_o(ver),
    .rdata_i(rdata), .supply_o(sup), .done_o(done), .pass_o(pass),
    .fail_o(fail), .fail_addr_o(fail_addr), .fail_phase_o(fail_phase));

  int errors = 0, checks = 0, cycles = 0;
  bit finished = 0;

  // ---------------- behavioural array model ----------------
  int need [NW];
  int pulses [NW];
  int cor_a = -1, cor_b = -1;
  bit clr_pulses = 0;
  bit pgm_seen = 0;

  function automatic logic [DW-1:0] gold(int a);
    logic [3:0] n = 4'(a);
    return 16'h1234 ^ {n, n, n, n};
  endfunction

  assign exp_data = gold(int'(addr));

  always_comb begin
    rdata = (pulses[addr] >= need[addr]) ? gold(int'(addr)) : '1;
    if (sup == 2'd2 && (int'(addr) == cor_a || int'(addr) == cor_b))
      rdata = ~gold(int'(addr));
  end

  always @(negedge clk) begin
    if (clr_pulses) begin
      for (int i = 0; i < NW; i++) pulses[i] = 0;
      pgm_seen = 0;
    end else begin
      if (pgm && !pgm_seen) pulses[addr] = pulses[addr] + 1;
      pgm_seen = pgm;
    end
  end

  // ---------------- expected trace ----------------
  typedef struct {
    int    a;
    bit    p;
    bit    v;
    int    s;
    bit    d;
    string req;
  } rec_t;
  rec_t q[$];
  bit   e_fail;
  int   e_faddr, e_phase;

  task automatic push(int a, bit p, bit v, int s, bit d, string r);
    rec_t x;
    x.a = a; x.p = p; x.v = v; x.s = s; x.d = d; x.req = r;
    q.push_back(x);
  endtask

  function automatic bit corrupt(int a);
    return (a == cor_a) || (a == cor_b);
  endfunction

  task automatic build();
    q.delete();
    e_fail = 0; e_faddr = 0; e_phase = 0;
    repeat (SCYC) push(0, 0, 0, 1, 0, "R1");
    for (int a = 0; a < NW; a++) begin
      repeat (PCYC) push(a, 1, 0, 1, 0, "R2");
      repeat (SCYC) push(a, 0, 0, 1, 0, "R2");
    end
    for (int a = 0; a < NW; a++) begin
      int got = 1;
      int rty = 0;
      while (1) begin
        push(a, 0, 1, 1, 0, "R3");
        if (got >= need[a]) break;
        if (rty == RMAX) begin
          e_fail = 1; e_faddr = a; e_phase = 1;
          push(-1, 0, 0, 0, 1, "R5");
          return;
        end
        rty++; got++;
        repeat (PCYC) push(a, 1, 0, 1, 0, "R4");
        repeat (SCYC) push(a, 0, 0, 1, 0, "R4");
      end
    end
    repeat (SCYC) push(0, 0, 0, 2, 0, "R6");
    for (int a = 0; a < NW; a++) begin
      push(a, 0, 1, 2, 0, "R6");
      if (corrupt(a) && !e_fail) begin
        e_fail = 1; e_faddr = a; e_phase = 2;
      end
    end
    push(-1, 0, 0, 0, 1, e_fail ? "R7" : "R8");
  endtask

  task automatic check(bit ok, string req, string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s", req, what);
    end
  endtask

  task automatic compare(rec_t r, int idx);
    bit ok;
    ok = (r.a < 0 || int'(addr) == r.a) && pgm == r.p && ver == r.v &&
         int'(sup) == r.s && done == r.d;
    check(ok, r.req, $sformatf("step %0d: got addr=%0d pgm=%0b ver=%0b sup=%0d done=%0b, expected addr=%0d pgm=%0b ver=%0b sup=%0d done=%0b",
          idx, addr, pgm, ver, sup, done, r.a, r.p, r.v, r.s, r.d));
    if (r.p && pgm)
      check(wdata == gold(int'(addr)), "R10",
            $sformatf("wdata got %h expected %h", wdata, gold(int'(addr))));
  endtask

  task automatic run(string name, int inject_at);
    build();
    clr_pulses = 1;
    @(posedge clk); @(posedge clk);
    clr_pulses = 0;
    @(negedge clk);
    start = 1;
    @(posedge clk);
    for (int i = 0; i < q.size(); i++) begin
      @(negedge clk);
      compare(q[i], i);
      start = (i == inject_at);  // R1: mid-run start must be ignored
    end
    start = 0;
    check(pass == !e_fail && fail == e_fail, e_fail ? (e_phase == 1 ? "R5" : "R7") : "R8",
          $sformatf("%s: got pass=%0b fail=%0b expected pass=%0b fail=%0b", name, pass, fail, !e_fail, e_fail));
    check(int'(fail_phase) == e_phase, e_phase == 1 ? "R5" : "R7",
          $sformatf("%s: phase got %0d expected %0d", name, fail_phase, e_phase));
    if (e_fail)
      check(int'(fail_addr) == e_faddr, e_phase == 1 ? "R5" : "R7",
            $sformatf("%s: fail addr got %0d expected %0d", name, fail_addr, e_faddr));
    repeat (8) @(negedge clk);
    check(done && pass == !e_fail && fail == e_fail, "R8",
          $sformatf("%s: held done=%0b pass=%0b fail=%0b expected 1/%0b/%0b", name, done, pass, fail, !e_fail, e_fail));
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      errors++; checks++;
      $display("FAIL watchdog: got %0d cycles expected completion", cycles);
      finish_up();
    end
  end

  initial begin
    for (int i = 0; i < NW; i++) begin need[i] = 1; pulses[i] = 0; end
    repeat (4) @(negedge clk);
    // R9: reset state
    check(sup == 2'd0 && !pgm && !ver && !done && !pass && !fail, "R9",
          $sformatf("in reset got sup=%0d pgm=%0b ver=%0b done=%0b pass=%0b fail=%0b expected 0", sup, pgm, ver, done, pass, fail));
    rst_n = 1;
    @(negedge clk);
    check(sup == 2'd0 && !pgm && !ver && !done && !pass && !fail, "R9",
          $sformatf("after reset got sup=%0d pgm=%0b ver=%0b done=%0b expected 0", sup, pgm, ver, done));

    // every word holds after one pulse
    run("clean", -1);

    // mixed retry counts, one word needs the full budget; stray start mid-run
    for (int i = 0; i < NW; i++) need[i] = 1 + (i % 4);
    need[6] = RMAX + 1;
    run("retries", 100);

    // last word exceeds the budget (R5 on final address)
    for (int i = 0; i < NW; i++) need[i] = 1 + (i % 2);
    need[NW-1] = RMAX + 2;
    run("exhaust", -1);

    // read-back corruption, first of two
    for (int i = 0; i < NW; i++) need[i] = 1;
    cor_a = 5; cor_b = 9;
    run("readback", -1);

    // only the last word corrupted (R7 on final address)
    cor_a = NW - 1; cor_b = -1;
    run("readback_last", -1);

    cor_a = -1;
    run("clean_again", -1);
    finish_up();
  end
endmodule